// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block is the control unit of a 32-bit core that carries out the entry into a handler. Each cycle it is idle, it looks at three request sources: a fast hardware interrupt, a normal hardware interrupt with a priority level and a number, and a synchronous exception with a vector. It checks each request against the enable bit and the priority level in the current status word, and picks one request. It takes a snapshot of the core state it needs, then runs the entry sequence. At the end it presents the new program counter, status word, stack pointers and R0 for one commit cycle.

The two interrupt classes take different paths. A fast interrupt copies the program counter and status word into backup registers and jumps to a fast-vector address. This path makes no memory access. A normal interrupt or an exception pushes the status word and then the program counter onto the interrupt stack, over a simple 32-bit memory port with a ready handshake. It then reads the handler address from a vector table. Exceptions with vectors below 256 read a fixed table near the top of the address space. Trap vectors from 256 to 511 read the relocatable table. An acknowledge pulse reports every accepted interrupt to the external priority logic.

Top module: `irq_entry_seq`

## Requirements
- R1: A normal request is accepted only when the status word enable bit (bit 16) is 1 and the current level (bits 27:24) is strictly less than the requested level. The accepted number is then latched and shown on `ackNum`, and the requested level becomes the new level in `newPsw`.
- R2: A fast request is accepted only when the enable bit is 1 and the current level is below 15.
- R3: When fast and normal requests are both acceptable, the fast one is entered. A normal request that is still held is entered by the next sequence.
- R4: At entry, R0 is saved as the user stack pointer when the user bit (bit 17) is 1, and as the interrupt stack pointer otherwise. `newPsw` is the captured status word with bit 20, the enable bit and the user bit cleared.
- R5: A fast entry puts the old program counter on `bkPc` and the old status word on `bkPsw`, loads the program counter from `fastVec` and sets the level to 15. It makes no memory access.
- R6: A normal entry writes the status word to interrupt stack pointer minus 4, then writes the program counter to interrupt stack pointer minus 8. It then reads the new program counter from `tblBase` plus 4 times the number.
- R7: An exception with a vector below 256 pushes the same two words. It reads the new program counter from 0xFFFFFFC0 plus 4 times the vector, with 32-bit wrap, and leaves the level unchanged.
- R8: An exception with a vector from 256 to 511 reads the new program counter from `tblBase` plus 4 times the low 8 bits of the vector.
- R9: At commit, `newR0` and `newIsp` equal the final interrupt stack pointer, and the sleep flag is 0.
- R10: Each memory access holds its request, address and data until `memReady`. Each access completes exactly once, whatever the wait.
- R11: `ackPulse` is high for exactly one cycle, in the commit cycle of an interrupt entry. `ackIsFast` marks a fast entry. Exceptions give no acknowledge.
- R12: `busy` is high from acceptance through the commit cycle. Requests that arrive while busy are ignored, and the memory port is quiet when not busy.
- R13: An exception is entered only when no interrupt is acceptable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fastReq | input | 1 | Fast interrupt pending |
| normReq | input | 1 | Normal interrupt pending |
| normLevel | input | 4 | Level of the normal request |
| normNum | input | 8 | Number of the normal request |
| excReq | input | 1 | Synchronous exception pending |
| excVec | input | 9 | Exception or trap vector |
| sleepSet | input | 1 | Sets the sleep flag while idle |
| curPc | input | 32 | Current program counter |
| curPsw | input | 32 | Current packed status word |
| curR0 | input | 32 | Current R0 (active stack pointer) |
| curUsp | input | 32 | Current user stack pointer |
| curIsp | input | 32 | Current interrupt stack pointer |
| tblBase | input | 32 | Relocatable vector table base |
| fastVec | input | 32 | Fast interrupt handler address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write when 1, read when 0 |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| memReady | input | 1 | Memory access completes this cycle |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Commit cycle; new state valid |
| newPc | output | 32 | New program counter |
| newPsw | output | 32 | New status word |
| newR0 | output | 32 | New R0 |
| newUsp | output | 32 | New user stack pointer |
| newIsp | output | 32 | New interrupt stack pointer |
| bkPc | output | 32 | Backup program counter |
| bkPsw | output | 32 | Backup status word |
| ackPulse | output | 1 | Interrupt acknowledge pulse |
| ackNum | output | 8 | Latched accepted interrupt number |
| ackIsFast | output | 1 | Acknowledge is for a fast interrupt |
| asleep | output | 1 | Sleep flag |

## Verification
The hardest case to reach is a request that arrives in the middle of a stalled sequence. The bench starts a normal entry with a memory model that adds wait cycles. It raises a fast request while `busy` is high, then checks that the commit and the acknowledge still belong to the normal entry and that the backup registers keep their values. Simultaneous requests are driven on the same cycle. This covers fast against normal, and interrupt against exception. A normal request is held across a fast entry to show it is taken next.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // Status word field positions; the return path decodes the saved word.
  localparam int PSW_I_BIT   = 16;
  localparam int PSW_U_BIT   = 17;
  localparam int PSW_PM_BIT  = 20;
  localparam int PSW_IPL_LSB = 24;

  typedef enum logic [1:0] {KIND_EXC, KIND_NORM, KIND_FAST} entry_kind_e;
  typedef enum logic [1:0] {SEL_PSW, SEL_PC, SEL_VEC} addr_sel_e;

  typedef struct packed {
    logic        capture;   // snapshot core state, start sequence
    entry_kind_e kind;      // entry class
    addr_sel_e   addrSel;   // which word the memory port carries
    logic        xferDone;  // memory access completes this cycle
    logic        commit;    // new state presented
  } seq_strobe_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fastReq,
  input  logic             normReq,
  input  logic [LVL_W-1:0] normLevel,
  input  logic             excReq,
  input  logic             pswIe,
  input  logic [LVL_W-1:0] pswIpl,
  input  logic             sleepSet,
  input  logic             memReady,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done,
  output logic             ackPulse,
  output logic             ackIsFast,
  output logic             asleep,
  output seq_strobe_t      stb
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  typedef enum logic [2:0] {ST_IDLE, ST_PUSH_PSW, ST_PUSH_PC, ST_READ_VEC, ST_COMMIT} state_e;

  state_e      state, stateNxt;
  entry_kind_e kindQ, pickKind;
  logic        acceptFast, acceptNorm, start;

  assign acceptFast = fastReq && pswIe && (pswIpl < MAX_LVL);
  assign acceptNorm = normReq && pswIe && (pswIpl < normLevel);
  assign start      = (state == ST_IDLE) && (acceptFast || acceptNorm || excReq);

  always_comb begin
    if (acceptFast)      pickKind = KIND_FAST;
    else if (acceptNorm) pickKind = KIND_NORM;
    else                 pickKind = KIND_EXC;
  end

  assign memReq = (state == ST_PUSH_PSW) || (state == ST_PUSH_PC) || (state == ST_READ_VEC);
  assign memWe  = (state == ST_PUSH_PSW) || (state == ST_PUSH_PC);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_COMMIT);
  assign ackPulse  = done && (kindQ != KIND_EXC);
  assign ackIsFast = done && (kindQ == KIND_FAST);

  always_comb begin
    stb.capture  = start;
    stb.kind     = start ? pickKind : kindQ;
    stb.xferDone = memReq && memReady;
    stb.commit   = done;
    case (state)
      ST_PUSH_PC:  stb.addrSel = SEL_PC;
      ST_READ_VEC: stb.addrSel = SEL_VEC;
      default:     stb.addrSel = SEL_PSW;
    endcase
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:     if (start) stateNxt = acceptFast ? ST_COMMIT : ST_PUSH_PSW;
      ST_PUSH_PSW: if (memReady) stateNxt = ST_PUSH_PC;
      ST_PUSH_PC:  if (memReady) stateNxt = ST_READ_VEC;
      ST_READ_VEC: if (memReady) stateNxt = ST_COMMIT;
      ST_COMMIT:   stateNxt = ST_IDLE;
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kindQ  <= KIND_EXC;
      asleep <= 1'b0;
    end else begin
      state <= stateNxt;
      if (start) begin
        kindQ  <= pickKind;
        asleep <= 1'b0;
      end else if (state == ST_IDLE && sleepSet) begin
        asleep <= 1'b1;
      end
    end
  end

  // R10: a stalled access keeps its request and target
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(stb.addrSel));
  // R11: acknowledge only in commit, one cycle wide
  p_ack_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |-> done);
  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ackPulse |=> !ackPulse);
  // R12: memory port quiet when idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq);
  // R9: sleep flag cleared by the time of commit
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !asleep);
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          LVL_W      = 4,
  parameter int          NUM_W      = 8,
  parameter int          VEC_W      = 9,
  parameter logic [31:0] FIXED_BASE = 32'hFFFF_FFC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_strobe_t      stb,
  input  logic [LVL_W-1:0] normLevel,
  input  logic [NUM_W-1:0] normNum,
  input  logic [VEC_W-1:0] excVec,
  input  logic [DW-1:0]    curPc,
  input  logic [DW-1:0]    curPsw,
  input  logic [DW-1:0]    curR0,
  input  logic [DW-1:0]    curUsp,
  input  logic [DW-1:0]    curIsp,
  input  logic [DW-1:0]    tblBase,
  input  logic [DW-1:0]    fastVec,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newPsw,
  output logic [DW-1:0]    newR0,
  output logic [DW-1:0]    newUsp,
  output logic [DW-1:0]    newIsp,
  output logic [DW-1:0]    bkPc,
  output logic [DW-1:0]    bkPsw,
  output logic [NUM_W-1:0] ackNum
);
  localparam logic [LVL_W-1:0] MAX_LVL  = {LVL_W{1'b1}};
  localparam int               LOW_BITS = 8;
  localparam logic [DW-1:0]    WORD     = DW'(4);

  logic [DW-1:0] pcQ, pswQ, savedPsw, savedPc, uspQ, ispQ, bkPcQ, bkPswQ, vecAddrQ;
  logic [NUM_W-1:0] ackNumQ;
  logic [DW-1:0] clearedPsw, excAddr;
  logic          userMode;

  assign userMode = curPsw[PSW_U_BIT];

  always_comb begin
    clearedPsw = curPsw;
    clearedPsw[PSW_I_BIT]  = 1'b0;
    clearedPsw[PSW_U_BIT]  = 1'b0;
    clearedPsw[PSW_PM_BIT] = 1'b0;
  end

  // Fixed table for low vectors, relocatable table for traps.
  always_comb begin
    if ((excVec >> LOW_BITS) == '0)
      excAddr = FIXED_BASE + (DW'(excVec) << 2);
    else
      excAddr = tblBase + (DW'(excVec[LOW_BITS-1:0]) << 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcQ <= '0; pswQ <= '0; savedPsw <= '0; savedPc <= '0;
      uspQ <= '0; ispQ <= '0; bkPcQ <= '0; bkPswQ <= '0;
      vecAddrQ <= '0; ackNumQ <= '0;
    end else if (stb.capture) begin
      savedPsw <= curPsw;
      savedPc  <= curPc;
      uspQ     <= userMode ? curR0 : curUsp;
      ispQ     <= userMode ? curIsp : curR0;
      pswQ     <= clearedPsw;
      case (stb.kind)
        KIND_FAST: begin
          bkPcQ  <= curPc;
          bkPswQ <= curPsw;
          pcQ    <= fastVec;
          pswQ[PSW_IPL_LSB +: LVL_W] <= MAX_LVL;
        end
        KIND_NORM: begin
          ackNumQ  <= normNum;
          vecAddrQ <= tblBase + (DW'(normNum) << 2);
          pswQ[PSW_IPL_LSB +: LVL_W] <= normLevel;
        end
        default: vecAddrQ <= excAddr;
      endcase
    end else if (stb.xferDone) begin
      if (stb.addrSel == SEL_VEC) pcQ  <= memRdata;
      else                        ispQ <= ispQ - WORD;
    end
  end

  assign memAddr  = (stb.addrSel == SEL_VEC) ? vecAddrQ : (ispQ - WORD);
  assign memWdata = (stb.addrSel == SEL_PSW) ? savedPsw : savedPc;

  assign newPc  = pcQ;
  assign newPsw = pswQ;
  assign newR0  = ispQ;
  assign newUsp = uspQ;
  assign newIsp = ispQ;
  assign bkPc   = bkPcQ;
  assign bkPsw  = bkPswQ;
  assign ackNum = ackNumQ;

  // R6: each completed push moves the interrupt stack down by one word
  p_isp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.xferDone && !stb.capture && stb.addrSel != SEL_VEC |=> ispQ == $past(ispQ) - WORD);
  // R4: mode bits are clear whenever new state is presented
  p_psw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |-> !newPsw[PSW_I_BIT] && !newPsw[PSW_U_BIT] && !newPsw[PSW_PM_BIT]);
  // R5: fast entry commits at the top level
  p_fast_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit && stb.kind == KIND_FAST |-> newPsw[PSW_IPL_LSB +: LVL_W] == MAX_LVL);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LVL_W = 4,
  parameter int NUM_W = 8,
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fastReq,
  input  logic             normReq,
  input  logic [LVL_W-1:0] normLevel,
  input  logic [NUM_W-1:0] normNum,
  input  logic             excReq,
  input  logic [VEC_W-1:0] excVec,
  input  logic             sleepSet,
  input  logic [DW-1:0]    curPc,
  input  logic [DW-1:0]    curPsw,
  input  logic [DW-1:0]    curR0,
  input  logic [DW-1:0]    curUsp,
  input  logic [DW-1:0]    curIsp,
  input  logic [DW-1:0]    tblBase,
  input  logic [DW-1:0]    fastVec,
  output logic             memReq,
  output logic             memWe,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  input  logic             memReady,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newPsw,
  output logic [DW-1:0]    newR0,
  output logic [DW-1:0]    newUsp,
  output logic [DW-1:0]    newIsp,
  output logic [DW-1:0]    bkPc,
  output logic [DW-1:0]    bkPsw,
  output logic             ackPulse,
  output logic [NUM_W-1:0] ackNum,
  output logic             ackIsFast,
  output logic             asleep
);
  seq_strobe_t stb;

  irq_entry_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fastReq(fastReq), .normReq(normReq), .normLevel(normLevel), .excReq(excReq),
    .pswIe(curPsw[PSW_I_BIT]), .pswIpl(curPsw[PSW_IPL_LSB +: LVL_W]),
    .sleepSet(sleepSet), .memReady(memReady),
    .memReq(memReq), .memWe(memWe), .busy(busy), .done(done),
    .ackPulse(ackPulse), .ackIsFast(ackIsFast), .asleep(asleep), .stb(stb)
  );

  irq_entry_dp #(.DW(DW), .LVL_W(LVL_W), .NUM_W(NUM_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .normLevel(normLevel), .normNum(normNum), .excVec(excVec),
    .curPc(curPc), .curPsw(curPsw), .curR0(curR0), .curUsp(curUsp), .curIsp(curIsp),
    .tblBase(tblBase), .fastVec(fastVec), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .newPc(newPc), .newPsw(newPsw), .newR0(newR0), .newUsp(newUsp), .newIsp(newIsp),
    .bkPc(bkPc), .bkPsw(bkPsw), .ackNum(ackNum)
  );
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/100ps
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fastReq = 0, normReq = 0, excReq = 0, sleepSet = 0;
  logic [3:0]  normLevel = 0;
  logic [7:0]  normNum = 0;
  logic [8:0]  excVec = 0;
  logic [31:0] curPc = 0, curPsw = 0, curR0 = 0, curUsp = 0, curIsp = 0, tblBase = 0, fastVec = 0;
  logic        memReq, memWe, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        busy, done, ackPulse, ackIsFast, asleep;
  logic [31:0] newPc, newPsw, newR0, newUsp, newIsp, bkPc, bkPsw;
  logic [7:0]  ackNum;

  int tests = 0, fails = 0;
  int memDelay = 0, waitCnt = 0;
  int wrCnt = 0, rdCnt = 0;
  logic [31:0] wrAddr [16];
  logic [31:0] wrData [16];
  logic [31:0] rdAddr [16];

  always #2.5 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .fastReq(fastReq), .normReq(normReq), .normLevel(normLevel),
    .normNum(normNum), .excReq(excReq), .excVec(excVec), .sleepSet(sleepSet),
    .curPc(curPc), .curPsw(curPsw), .curR0(curR0), .curUsp(curUsp), .curIsp(curIsp),
    .tblBase(tblBase), .fastVec(fastVec),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .newPc(newPc), .newPsw(newPsw), .newR0(newR0),
    .newUsp(newUsp), .newIsp(newIsp), .bkPc(bkPc), .bkPsw(bkPsw),
    .ackPulse(ackPulse), .ackNum(ackNum), .ackIsFast(ackIsFast), .asleep(asleep)
  );

  function automatic logic [31:0] vecData(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction
  assign memRdata = vecData(memAddr);

  // Memory model: ready after memDelay waiting cycles, logs each completed access.
  initial memReady = 1'b0;
  always @(negedge clk) begin
    if (memReq) begin
      if (waitCnt >= memDelay) begin
        memReady <= 1'b1;
        waitCnt  <= 0;
        if (memWe) begin
          wrAddr[wrCnt % 16] <= memAddr; wrData[wrCnt % 16] <= memWdata; wrCnt <= wrCnt + 1;
        end else begin
          rdAddr[rdCnt % 16] <= memAddr; rdCnt <= rdCnt + 1;
        end
      end else begin
        memReady <= 1'b0;
        waitCnt  <= waitCnt + 1;
      end
    end else begin
      memReady <= 1'b0;
      waitCnt  <= 0;
    end
  end

  function automatic logic [31:0] mkPsw(input logic ie, u, pm, input logic [3:0] lvl, input logic [31:0] flags);
    return (flags & 32'h0000_FFFF) | (32'(ie) << 16) | (32'(u) << 17) | (32'(pm) << 20) | (32'(lvl) << 24);
  endfunction
  function automatic logic [31:0] entryPsw(input logic [31:0] p, input logic [3:0] lvl);
    return (p & ~32'h0F13_0000) | (32'(lvl) << 24);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    if (done !== 1'b1) chk({tag, " commit reached"}, 32'(done), 32'd1);
  endtask

  task automatic dropAll();
    fastReq = 0; normReq = 0; excReq = 0;
    @(negedge clk);
  endtask

  task automatic setCore(input logic [31:0] psw, r0, usp, isp, pc);
    curPsw = psw; curR0 = r0; curUsp = usp; curIsp = isp; curPc = pc;
  endtask

  task automatic tReset();
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset memReq", 32'(memReq), 0);
    chk("R11 reset ack", 32'(ackPulse), 0);
    chk("R9 reset asleep", 32'(asleep), 0);
  endtask

  task automatic tFast();
    int w0 = wrCnt, r0c = rdCnt;
    logic [31:0] p = mkPsw(1, 0, 1, 4'd3, 32'h000F);
    setCore(p, 32'h2000, 32'h0, 32'h1111, 32'h1234);
    fastVec = 32'hF000;
    fastReq = 1; @(negedge clk);
    chk("R5 fast commit next cycle", 32'(done), 1);
    waitDone("R5");
    chk("R5 fast newPc", newPc, 32'hF000);
    chk("R5 fast bkPc", bkPc, 32'h1234);
    chk("R5 fast bkPsw", bkPsw, p);
    chk("R5 fast level 15", newPsw, entryPsw(p, 4'hF));
    chk("R5 fast no writes", 32'(wrCnt - w0), 0);
    chk("R5 fast no reads", 32'(rdCnt - r0c), 0);
    chk("R4 fast isp from R0", newIsp, 32'h2000);
    chk("R9 fast newR0", newR0, 32'h2000);
    chk("R11 fast ack", 32'(ackPulse), 1);
    chk("R11 fast ack kind", 32'(ackIsFast), 1);
    dropAll();
    chk("R11 ack one cycle", 32'(ackPulse), 0);
  endtask

  task automatic tNormal(input int dly);
    int w0 = wrCnt, r0c = rdCnt;
    logic [31:0] p = mkPsw(1, 0, 0, 4'd2, 32'h0003);
    memDelay = dly;
    setCore(p, 32'h3000, 32'h55, 32'h9999, 32'h0000_4444);
    tblBase = 32'h8000; normLevel = 4'd5; normNum = 8'h21;
    normReq = 1; @(negedge clk);
    chk("R12 busy after accept", 32'(busy), 1);
    waitDone("R6");
    chk("R10 two writes", 32'(wrCnt - w0), 2);
    chk("R10 one read", 32'(rdCnt - r0c), 1);
    chk("R6 psw push addr", wrAddr[w0 % 16], 32'h2FFC);
    chk("R6 psw push data", wrData[w0 % 16], p);
    chk("R6 pc push addr", wrAddr[(w0 + 1) % 16], 32'h2FF8);
    chk("R6 pc push data", wrData[(w0 + 1) % 16], 32'h4444);
    chk("R6 vector addr", rdAddr[r0c % 16], 32'h8084);
    chk("R6 newPc", newPc, vecData(32'h8084));
    chk("R1 newPsw level", newPsw, entryPsw(p, 4'd5));
    chk("R1 ackNum", 32'(ackNum), 32'h21);
    chk("R9 newR0", newR0, 32'h2FF8);
    chk("R4 usp kept", newUsp, 32'h55);
    chk("R11 normal ack", 32'(ackPulse), 1);
    chk("R11 normal not fast", 32'(ackIsFast), 0);
    dropAll();
    memDelay = 0;
  endtask

  task automatic tReject();
    setCore(mkPsw(1, 0, 0, 4'd5, 0), 32'h3000, 0, 0, 0);
    normLevel = 4'd5; normReq = 1;
    repeat (3) @(negedge clk);
    chk("R1 equal level rejected", 32'(busy), 0);
    normReq = 0;
    setCore(mkPsw(1, 0, 0, 4'hF, 0), 32'h3000, 0, 0, 0);
    fastReq = 1;
    repeat (3) @(negedge clk);
    chk("R2 level 15 rejects fast", 32'(busy), 0);
    setCore(mkPsw(0, 0, 0, 4'd0, 0), 32'h3000, 0, 0, 0);
    normLevel = 4'd9; normReq = 1;
    repeat (3) @(negedge clk);
    chk("R1 R2 disabled rejects", 32'(busy), 0);
    dropAll();
  endtask

  task automatic tUserExc();
    int w0 = wrCnt, r0c = rdCnt;
    logic [31:0] p = mkPsw(1, 1, 1, 4'd6, 32'h0005);
    setCore(p, 32'h7000, 32'h1, 32'h4000, 32'hABC0);
    excVec = 9'd23; excReq = 1; @(negedge clk);
    waitDone("R7");
    chk("R4 user R0 to usp", newUsp, 32'h7000);
    chk("R4 user pushes on isp", wrAddr[w0 % 16], 32'h3FFC);
    chk("R9 newIsp", newIsp, 32'h3FF8);
    chk("R7 fixed table addr", rdAddr[r0c % 16], 32'hFFFF_FFC0 + 32'd92);
    chk("R7 newPc", newPc, vecData(32'hFFFF_FFC0 + 32'd92));
    chk("R7 level unchanged", newPsw, entryPsw(p, 4'd6));
    chk("R11 exception no ack", 32'(ackPulse), 0);
    dropAll();
  endtask

  task automatic tTrap();
    int r0c = rdCnt;
    setCore(mkPsw(1, 0, 0, 4'd1, 0), 32'h5000, 0, 0, 32'h10);
    tblBase = 32'h8000; excVec = 9'h105; excReq = 1; @(negedge clk);
    waitDone("R8");
    chk("R8 trap vector addr", rdAddr[r0c % 16], 32'h8014);
    chk("R8 trap newPc", newPc, vecData(32'h8014));
    dropAll();
  endtask

  task automatic tBoth();
    int r0c;
    setCore(mkPsw(1, 0, 0, 4'd1, 0), 32'h6000, 0, 0, 32'h20);
    fastVec = 32'hF100; tblBase = 32'h9000; normLevel = 4'd4; normNum = 8'h07;
    fastReq = 1; normReq = 1; @(negedge clk);
    waitDone("R3");
    chk("R3 fast first", 32'(ackIsFast), 1);
    chk("R3 fast pc", newPc, 32'hF100);
    fastReq = 0; r0c = rdCnt;
    @(negedge clk); @(negedge clk);
    waitDone("R3");
    chk("R3 normal next", 32'(ackPulse & ~ackIsFast), 1);
    chk("R3 normal vector", rdAddr[r0c % 16], 32'h901C);
    dropAll();
  endtask

  task automatic tIrqOverExc();
    int r0c = rdCnt;
    setCore(mkPsw(1, 0, 0, 4'd0, 0), 32'h6000, 0, 0, 32'h30);
    tblBase = 32'hA000; normLevel = 4'd2; normNum = 8'h03; excVec = 9'd21;
    normReq = 1; excReq = 1; @(negedge clk);
    waitDone("R13");
    chk("R13 interrupt wins", 32'(ackPulse), 1);
    chk("R13 interrupt vector", rdAddr[r0c % 16], 32'hA00C);
    normReq = 0; excReq = 0;
    @(negedge clk);
  endtask

  task automatic tBusyIgnore();
    logic [31:0] oldBk = bkPc;
    memDelay = 3;
    setCore(mkPsw(1, 0, 0, 4'd1, 0), 32'h3000, 0, 0, 32'h40);
    tblBase = 32'h8000; normLevel = 4'd3; normNum = 8'h02; fastVec = 32'hF200;
    normReq = 1; @(negedge clk);
    normReq = 0; @(negedge clk);
    fastReq = 1;
    waitDone("R12");
    chk("R12 busy held to commit", 32'(busy), 1);
    chk("R12 late fast ignored", 32'(ackIsFast), 0);
    chk("R12 late fast pc", newPc, vecData(32'h8008));
    chk("R12 backup untouched", bkPc, oldBk);
    dropAll();
    chk("R12 idle after commit", 32'(busy), 0);
    memDelay = 0;
  endtask

  task automatic tSleep();
    sleepSet = 1; @(negedge clk);
    sleepSet = 0;
    chk("R9 sleep set", 32'(asleep), 1);
    setCore(mkPsw(1, 0, 0, 4'd0, 0), 32'h3000, 0, 0, 0);
    excVec = 9'd30; excReq = 1; @(negedge clk);
    waitDone("R9");
    chk("R9 sleep cleared", 32'(asleep), 0);
    dropAll();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tReset();
    tFast();
    tNormal(0);
    tNormal(2);
    tReject();
    tUserExc();
    tTrap();
    tBoth();
    tIrqOverExc();
    tBusyIgnore();
    tSleep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule